// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a two-bank synchronous DRAM. It takes the memory from power-on to a usable state and then hands over to the normal command path. After a synchronous reset it holds clock enable low with the chip deselected. It then raises clock enable and keeps the command pins at NOP for a long settling pause. Next it issues one precharge of both banks, followed by a run of auto-refresh commands and a single mode-register load. Each command is followed by the recovery time the memory needs before it accepts the next one. When the last wait has run out, `ready` goes high and stays high.

A strap input picks one of two legal orderings, and the block samples it once when it leaves reset. With the strap low, the block uses the long pause and performs the refresh run before the mode load. With the strap high, it uses a shorter pause and loads the mode register before a shorter refresh run. All pauses, recovery times and refresh counts are parameters given in clock cycles. The mode word comes from an input, and the block always drives its reserved bit 7 low.

Top module: `sdram_boot_seq`

## Requirements
- R1: While `rst` is high, `cke` is 0, `cs_n` is 1 and `ready` is 0.
- R2: After reset, `cke` rises and stays high. Every cycle before `ready` is either NOP (`cs_n`=0, `ras_n`=`cas_n`=`we_n`=1) or one of the three commands. The first command comes exactly PAUSE_LONG_CYC cycles after `cke` rises when the strap is 0, and exactly PAUSE_SHORT_CYC cycles after when the strap is 1.
- R3: The first command is a precharge of both banks: `cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=0, with `addr` equal to 1 at bit 8 and 0 at every other bit.
- R4: The next command comes exactly ROW_PRE_CYC cycles after the precharge.
- R5: With the strap at 0, the precharge is followed by REF_LONG_CNT auto-refreshes (`cs_n`=0, `ras_n`=0, `cas_n`=0, `we_n`=1) and then one mode load.
- R6: With the strap at 1, the precharge is followed by one mode load and then REF_SHORT_CNT auto-refreshes.
- R7: Each auto-refresh is followed by exactly ROW_CYCLE_CYC cycles before the next command, or before `ready` when it is the last step.
- R8: A mode load drives `cs_n`, `ras_n`, `cas_n` and `we_n` all to 0. Its `addr` equals `mode_word` with bit 7 forced to 0.
- R9: Each mode load is followed by exactly MODE_GAP_CYC cycles before the next command, or before `ready` when it is the last step.
- R10: `ready` rises exactly when the final wait of the chosen ordering ends. It then stays high, with only NOP on the pins, until the next reset.
- R11: `seq_sel` is sampled only in the first cycle after reset. Changing it later has no effect on the ordering.
- R12: Asserting `rst` in the middle of the sequence abandons it. The next release starts again from the pause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_sel | input | 1 | Ordering strap: 0 refreshes before the mode load, 1 loads the mode first |
| mode_word | input | ADDR_W | Value for the mode-register load |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address lines carrying the precharge-all flag and the mode word |
| ready | output | 1 | Initialization finished |

## Verification
A state or counter error shows up on the command pins at the first command it affects, and the bench times every command against the cycle in which `cke` rose. A refresh counter that is off by one moves the mode load, or `ready`, by one whole row-cycle time. A strap latched in the wrong place reverses the command order within ROW_PRE_CYC cycles of the precharge. A wrong timer reload shifts the next command by one cycle, and the cycle-exact comparisons catch that.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;
  typedef enum logic [1:0] {CMD_NOP, CMD_PRE, CMD_REF, CMD_MRS} boot_cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PAUSE, ST_PRE, ST_PRE_GAP, ST_REF, ST_REF_GAP,
    ST_MRS, ST_MRS_GAP, ST_DONE
  } boot_state_e;
endpackage

// File: rtl/boot_timer.sv
module boot_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/boot_cmd_drive.sv
module boot_cmd_drive
  import sdram_boot_pkg::*;
#(
  parameter int ADDR_W        = 10,
  parameter int PRE_ALL_BIT   = 8,
  parameter int MODE_ZERO_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  boot_cmd_e         cmd,
  input  logic              cke_en,
  input  logic              done,
  input  logic [ADDR_W-1:0] mode_word,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic              ready
);
  localparam logic [ADDR_W-1:0] PRE_ADDR  = ADDR_W'(1) << PRE_ALL_BIT;
  localparam logic [ADDR_W-1:0] MODE_MASK = ~(ADDR_W'(1) << MODE_ZERO_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      cke   <= 1'b0;
      cs_n  <= 1'b1;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      we_n  <= 1'b1;
      addr  <= '0;
      ready <= 1'b0;
    end else begin
      cke   <= cke_en;
      cs_n  <= ~cke_en;
      ready <= done;
      addr  <= '0;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      we_n  <= 1'b1;
      case (cmd)
        CMD_PRE: begin ras_n <= 1'b0; we_n <= 1'b0; addr <= PRE_ADDR; end
        CMD_REF: begin ras_n <= 1'b0; cas_n <= 1'b0; end
        CMD_MRS: begin
          ras_n <= 1'b0; cas_n <= 1'b0; we_n <= 1'b0;
          addr  <= mode_word & MODE_MASK;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
  import sdram_boot_pkg::*;
#(
  parameter int ADDR_W          = 10,
  parameter int PRE_ALL_BIT     = 8,
  parameter int MODE_ZERO_BIT   = 7,
  parameter int PAUSE_LONG_CYC  = 20_000_000,
  parameter int PAUSE_SHORT_CYC = 10_000_000,
  parameter int ROW_PRE_CYC     = 3,
  parameter int ROW_CYCLE_CYC   = 8,
  parameter int MODE_GAP_CYC    = 2,
  parameter int REF_LONG_CNT    = 8,
  parameter int REF_SHORT_CNT   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seq_sel,
  input  logic [ADDR_W-1:0] mode_word,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic              ready
);
  localparam int MAX_WAIT = (PAUSE_LONG_CYC > PAUSE_SHORT_CYC) ? PAUSE_LONG_CYC : PAUSE_SHORT_CYC;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam int MAX_REF  = (REF_LONG_CNT > REF_SHORT_CNT) ? REF_LONG_CNT : REF_SHORT_CNT;
  localparam int REF_W    = $clog2(MAX_REF + 1);

  boot_state_e      state_q, state_d;
  logic             long_q;
  logic [REF_W-1:0] refs_q;
  logic [REF_W-1:0] refs_target;
  logic             tmr_load, tmr_expired;
  logic [CNT_W-1:0] tmr_val;
  boot_cmd_e        cmd_d;

  assign refs_target = long_q ? REF_W'(REF_LONG_CNT) : REF_W'(REF_SHORT_CNT);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE: begin
        state_d  = ST_PAUSE;
        tmr_load = 1'b1;
        tmr_val  = seq_sel ? CNT_W'(PAUSE_SHORT_CYC - 1) : CNT_W'(PAUSE_LONG_CYC - 1);
      end
      ST_PAUSE:   if (tmr_expired) state_d = ST_PRE;
      ST_PRE: begin
        state_d  = ST_PRE_GAP;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(ROW_PRE_CYC - 2);
      end
      ST_PRE_GAP: if (tmr_expired) state_d = long_q ? ST_REF : ST_MRS;
      ST_REF: begin
        state_d  = ST_REF_GAP;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(ROW_CYCLE_CYC - 2);
      end
      ST_REF_GAP: begin
        if (tmr_expired) begin
          if (refs_q == refs_target) state_d = long_q ? ST_MRS : ST_DONE;
          else                       state_d = ST_REF;
        end
      end
      ST_MRS: begin
        state_d  = ST_MRS_GAP;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(MODE_GAP_CYC - 2);
      end
      ST_MRS_GAP: if (tmr_expired) state_d = long_q ? ST_DONE : ST_REF;
      ST_DONE:    state_d = ST_DONE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    case (state_d)
      ST_PRE:  cmd_d = CMD_PRE;
      ST_REF:  cmd_d = CMD_REF;
      ST_MRS:  cmd_d = CMD_MRS;
      default: cmd_d = CMD_NOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      long_q  <= 1'b0;
      refs_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE) begin
        long_q <= ~seq_sel;
        refs_q <= '0;
      end else if (state_q == ST_REF) begin
        refs_q <= refs_q + 1'b1;
      end
    end
  end

  boot_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  boot_cmd_drive #(
    .ADDR_W        (ADDR_W),
    .PRE_ALL_BIT   (PRE_ALL_BIT),
    .MODE_ZERO_BIT (MODE_ZERO_BIT)
  ) u_drive (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd_d),
    .cke_en    (state_d != ST_IDLE),
    .done      (state_d == ST_DONE),
    .mode_word (mode_word),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .addr      (addr),
    .ready     (ready)
  );
endmodule

// File: rtl/sdram_boot_seq_chk.sv
module sdram_boot_seq_chk #(
  parameter int ADDR_W        = 10,
  parameter int PRE_ALL_BIT   = 8,
  parameter int MODE_ZERO_BIT = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic              ready
);
  logic is_cmd, is_pre, is_mrs;
  assign is_cmd = !cs_n && !(ras_n && cas_n && we_n);
  assign is_pre = !cs_n && !ras_n && cas_n && !we_n;
  assign is_mrs = !cs_n && !ras_n && !cas_n && !we_n;

  AST_CKE_LEADS_CMD: assert property (@(posedge clk) disable iff (rst) is_cmd |-> $past(cke)); // R2
  AST_PRE_ALL_ADDR: assert property (@(posedge clk) disable iff (rst) is_pre |-> (addr == (ADDR_W'(1) << PRE_ALL_BIT))); // R3
  AST_CMD_SPACED: assert property (@(posedge clk) disable iff (rst) is_cmd |=> !is_cmd); // R4
  AST_MODE_BIT_LOW: assert property (@(posedge clk) disable iff (rst) is_mrs |-> !addr[MODE_ZERO_BIT]); // R8
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst) ready |=> ready); // R10
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst) ready |-> (!is_cmd && cke)); // R10
endmodule

bind sdram_boot_seq sdram_boot_seq_chk #(
  .ADDR_W(ADDR_W), .PRE_ALL_BIT(PRE_ALL_BIT), .MODE_ZERO_BIT(MODE_ZERO_BIT)
) u_chk (.*);

// File: tb/sdram_boot_seq_bench.sv
module sdram_boot_seq_bench;
  localparam int AW    = 10;
  localparam int PW_L  = 40;
  localparam int PW_S  = 20;
  localparam int T_RP  = 3;
  localparam int T_RC  = 6;
  localparam int T_MRD = 2;
  localparam int REF_L = 8;
  localparam int REF_S = 2;
  localparam int K_PRE = 1, K_REF = 2, K_MRS = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic seq_sel = 1'b0;
  logic [AW-1:0] mode_word = '0;
  logic cke, cs_n, ras_n, cas_n, we_n, ready;
  logic [AW-1:0] addr;

  int checks = 0;
  int failures = 0;
  int tick = 0;

  int ev_cyc [0:31];
  int ev_kind [0:31];
  logic [AW-1:0] ev_addr [0:31];
  int n_ev, cke_rise, ready_cyc, bad, late_cmd, ready_lost;

  always #5 clk = ~clk;

  sdram_boot_seq #(
    .ADDR_W(AW), .PAUSE_LONG_CYC(PW_L), .PAUSE_SHORT_CYC(PW_S),
    .ROW_PRE_CYC(T_RP), .ROW_CYCLE_CYC(T_RC), .MODE_GAP_CYC(T_MRD),
    .REF_LONG_CNT(REF_L), .REF_SHORT_CNT(REF_S)
  ) u_sdram_boot_seq (
    .clk(clk), .rst(rst), .seq_sel(seq_sel), .mode_word(mode_word),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ready(ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    tick++;
    if (tick > 100000) begin
      chk(1'b0, "watchdog", tick, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // R1: reset state observed at the ports
  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(cke == 1'b0 && cs_n == 1'b1 && ready == 1'b0, "R1",
        {29'd0, cke, cs_n, ready}, 3'b010);
    rst = 1'b0;
  endtask

  // Records every command seen after reset release; stop_ev = 0 runs to ready
  task automatic capture(input int toggle_at, input int stop_ev);
    int cyc;
    int post;
    n_ev = 0; cke_rise = -1; ready_cyc = -1; bad = 0; late_cmd = 0; ready_lost = 0;
    post = 0;
    for (cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      if (cyc == toggle_at) seq_sel = ~seq_sel;
      if (cke && cke_rise < 0) cke_rise = cyc;
      if (cke_rise >= 0 && (!cke || cs_n)) bad++;
      if (!cs_n && !(ras_n && cas_n && we_n)) begin
        if (ready_cyc >= 0) late_cmd++;
        else if (n_ev < 32) begin
          ev_cyc[n_ev]  = cyc;
          ev_addr[n_ev] = addr;
          if (!ras_n && cas_n && !we_n)       ev_kind[n_ev] = K_PRE;
          else if (!ras_n && !cas_n && we_n)  ev_kind[n_ev] = K_REF;
          else if (!ras_n && !cas_n && !we_n) ev_kind[n_ev] = K_MRS;
          else begin ev_kind[n_ev] = 0; bad++; end
          n_ev++;
        end
      end
      if (ready && ready_cyc < 0) ready_cyc = cyc;
      if (ready_cyc >= 0) begin
        if (!ready) ready_lost++;
        post++;
        if (post > 8) break;
      end
      if (stop_ev != 0 && n_ev >= stop_ev) break;
    end
  endtask

  task automatic check_run(input bit lng, input logic [AW-1:0] mw);
    int exp_n;
    int t;
    int idx;
    logic [AW-1:0] exp_mode;
    exp_n = 2 + (lng ? REF_L : REF_S);
    exp_mode = mw & ~(AW'(1) << 7);
    chk(n_ev == exp_n, lng ? "R5 count" : "R6 count", n_ev, exp_n);
    chk(bad == 0, "R2 pins", bad, 0);
    chk(ev_cyc[0] - cke_rise == (lng ? PW_L : PW_S), "R2 pause", ev_cyc[0] - cke_rise, lng ? PW_L : PW_S);
    chk(ev_kind[0] == K_PRE, "R3 kind", ev_kind[0], K_PRE);
    chk(ev_addr[0] == 10'h100, "R3 addr", int'(ev_addr[0]), 'h100);
    if (n_ev == exp_n) begin
      t = ev_cyc[0] + T_RP;
      idx = 1;
      if (lng) begin
        for (int i = 0; i < REF_L; i++) begin
          chk(ev_kind[idx] == K_REF, "R5 order", ev_kind[idx], K_REF);
          chk(ev_cyc[idx] == t, (i == 0) ? "R4" : "R7", ev_cyc[idx], t);
          t += T_RC; idx++;
        end
        chk(ev_kind[idx] == K_MRS, "R5 mode last", ev_kind[idx], K_MRS);
        chk(ev_cyc[idx] == t, "R7 gap", ev_cyc[idx], t);
        chk(ev_addr[idx] == exp_mode, "R8", int'(ev_addr[idx]), int'(exp_mode));
        t += T_MRD;
        chk(ready_cyc == t, "R9 ready", ready_cyc, t);
      end else begin
        chk(ev_kind[idx] == K_MRS, "R6 mode first", ev_kind[idx], K_MRS);
        chk(ev_cyc[idx] == t, "R4", ev_cyc[idx], t);
        chk(ev_addr[idx] == exp_mode, "R8", int'(ev_addr[idx]), int'(exp_mode));
        t += T_MRD; idx++;
        for (int i = 0; i < REF_S; i++) begin
          chk(ev_kind[idx] == K_REF, "R6 order", ev_kind[idx], K_REF);
          chk(ev_cyc[idx] == t, (i == 0) ? "R9" : "R7", ev_cyc[idx], t);
          t += T_RC; idx++;
        end
        chk(ready_cyc == t, "R7 ready", ready_cyc, t);
      end
    end
    chk(ready_cyc >= 0, "R10 ready seen", ready_cyc, 0);
    chk(ready_lost == 0 && late_cmd == 0, "R10 hold", ready_lost + late_cmd, 0);
  endtask

  task automatic test_long();
    seq_sel = 1'b0; mode_word = 10'h032;
    do_reset();
    capture(-1, 0);
    check_run(1'b1, 10'h032);
  endtask

  task automatic test_short();
    seq_sel = 1'b1; mode_word = 10'h3A5;
    do_reset();
    capture(-1, 0);
    check_run(1'b0, 10'h3A5);
  endtask

  task automatic test_strap_ignored();
    seq_sel = 1'b0; mode_word = 10'h0FF;
    do_reset();
    capture(3, 0);
    chk(ev_kind[1] == K_REF, "R11 late strap high", ev_kind[1], K_REF);
    check_run(1'b1, 10'h0FF);
    seq_sel = 1'b1;
    do_reset();
    capture(5, 0);
    chk(ev_kind[1] == K_MRS, "R11 late strap low", ev_kind[1], K_MRS);
    check_run(1'b0, 10'h0FF);
  endtask

  task automatic test_mid_reset();
    seq_sel = 1'b1; mode_word = 10'h021;
    do_reset();
    capture(-1, 3);
    chk(n_ev == 3 && ready_cyc < 0, "R12 partial", n_ev, 3);
    do_reset();
    capture(-1, 0);
    chk(ev_cyc[0] - cke_rise == PW_S, "R12 restart pause", ev_cyc[0] - cke_rise, PW_S);
    check_run(1'b0, 10'h021);
  endtask

  initial begin
    test_long();
    test_short();
    test_strap_ignored();
    test_mid_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule